// File: doc/BRIEF.md
# Aliased Control and Status Register Bank

This block is the register bank of a measurement peripheral. It decodes a plain single-cycle bus (address, write strobe, write data, read data) and holds six registers: an alarm control register, a status register, a threshold register, a measurement control register, a period register and a reference divider register. Their fields leave the block as plain level outputs for the rest of the peripheral. Hardware inputs raise status flags and report a live comparator level.

Every register is reachable at its base offset and at three aliases above it. Address bits 3:2 select the access: 0 is a plain write, 1 ORs the write data into the register, 2 clears the bits written as 1, and 3 inverts the bits written as 1. Software can therefore change one field without a read-modify-write and without racing the hardware flags. The measurement control register also carries two command bits. Writing a 1 to either of them produces a one-cycle strobe for the sequencer. They are not stored.

The bus has no handshake. Every write completes in the cycle it is presented, and `bus_rdata` is a combinational function of `bus_addr`. No valid/ready flow control is needed because nothing can stall.

Top module: `alias_regbank`

## Requirements
- R1: A write with address bits 3:2 = 0 stores the write data ANDed with the register's writable mask. The masks are: alarm control 0x0000_020C, status 0x0001_0200, threshold 0xFFFF_0000, measurement control 0x830C_0000, period 0x00FF_FFFF, divider 0x80FF_0000. Bits outside the mask read 0.
- R2: A write to base+0x4 sets to 1 each writable bit that is 1 in the write data and leaves all other bits unchanged.
- R3: A write to base+0x8 clears to 0 each writable bit that is 1 in the write data and leaves all other bits unchanged.
- R4: A write to base+0xC inverts each writable bit that is 1 in the write data and leaves all other bits unchanged.
- R5: A read at the base or at any of the three aliases returns the register's value. Reads at an unmapped address return 0. Writes to an unmapped address change no register.
- R6: The register bases and field outputs are as follows:
  - 0x000: `alarm_ie` is bit 9; `alarm_mode` is bits 3:2.
  - 0x010: `alarm_flag` is bit 9; `drdy_flag` is bit 16.
  - 0x030: `thr_level` is bits 31:16.
  - 0x200: `mon_enable` is bit 31; `meas_mode` is bits 25:24; `res_sel` is bits 19:18.
  - 0x270: `period_cnt` is bits 23:0.
  - 0x280: `refdiv_en` is bit 31; `refdiv_val` is bits 23:16.
  - A write changes a field output from the clock edge that takes the write.
- R7: A write to 0x200, 0x204 or 0x20C with bit 30 set raises `start_strobe` for exactly the one cycle after the write edge. Bit 29 does the same for `stop_strobe`. A write to 0x208 raises neither strobe. Both bits read as 0.
- R8: `hw_alarm_set` and `hw_drdy_set` set status bits 9 and 16 at the next edge. When a hardware set and a software clear of the same flag arrive in the same cycle, the flag ends as 1.
- R9: Status bit 13 reads the live `hw_above` input. Writes do not affect it.
- R10: After reset every register, every field output and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| hw_alarm_set | input | 1 | Hardware set of the alarm flag |
| hw_drdy_set | input | 1 | Hardware set of the data-ready flag |
| hw_above | input | 1 | Live comparator level shown at status bit 13 |
| alarm_ie | output | 1 | Alarm interrupt enable |
| alarm_mode | output | 2 | Alarm compare mode |
| mon_enable | output | 1 | Monitor enable |
| meas_mode | output | 2 | Measurement mode select |
| res_sel | output | 2 | Resolution select |
| start_strobe | output | 1 | One-cycle start command |
| stop_strobe | output | 1 | One-cycle stop command |
| thr_level | output | 16 | Threshold value |
| period_cnt | output | 24 | Periodic measurement interval |
| refdiv_en | output | 1 | Reference divider enable |
| refdiv_val | output | 8 | Reference divide value |
| alarm_flag | output | 1 | Alarm interrupt flag |
| drdy_flag | output | 1 | Data-ready flag |

## Verification
A wrong alias operation or a wrong writable mask shows up at the field outputs one edge after the write. The same fault reaches `bus_rdata` as soon as the address is presented, because the read path holds no register. A decode fault that maps an alias to the wrong base shows up when a read at that alias differs from the read at the base. A lost hardware set shows up in the status read one edge after the set and the clear meet. A strobe that fires on a clear alias, or that lasts two cycles, shows up on the cycle after the write edge or on the cycle after that.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;

  localparam int DW   = 32;
  localparam int NREG = 6;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_e;

  localparam int IDX_ACTL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_THR  = 2;
  localparam int IDX_MCTL = 3;
  localparam int IDX_PER  = 4;
  localparam int IDX_DIV  = 5;

  localparam logic [11:0] REG_OFS [NREG] = '{
    12'h000, 12'h010, 12'h030, 12'h200, 12'h270, 12'h280
  };

  localparam logic [DW-1:0] REG_MASK [NREG] = '{
    32'h0000_020C, 32'h0001_0200, 32'hFFFF_0000,
    32'h830C_0000, 32'h00FF_FFFF, 32'h80FF_0000
  };

  localparam int START_BIT = 30;
  localparam int STOP_BIT  = 29;
  localparam int ALARM_BIT = 9;
  localparam int ABOVE_BIT = 13;
  localparam int DRDY_BIT  = 16;

  function automatic logic [DW-1:0] apply_op(alias_op_e op, logic [DW-1:0] cur,
                                             logic [DW-1:0] wd);
    logic [DW-1:0] r;
    unique case (op)
      OP_WRITE: r = wd;
      OP_SET:   r = cur | wd;
      OP_CLR:   r = cur & ~wd;
      default:  r = cur ^ wd;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/arb_addr_decode.sv
module arb_addr_decode
  import alias_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output alias_op_e         op
);

  logic unused_lo;
  assign unused_lo = ^addr[1:0];
  assign op = alias_op_e'(addr[3:2]);

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REG_OFS[g]);
    assign hit[g] = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]);
  end

endmodule

// File: rtl/arb_reg.sv
module arb_reg
  import alias_regbank_pkg::*;
#(
  parameter logic [DW-1:0] MASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  alias_op_e     op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] hw_set,
  output logic [DW-1:0] q
);

  logic [DW-1:0] sw_next;

  always_comb begin
    sw_next = q;
    if (we) sw_next = apply_op(op, q, wdata);
  end

  // hardware set is ORed after the software update, so it wins a clash
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (sw_next | hw_set) & MASK;
  end

endmodule

// File: rtl/arb_strobe.sv
module arb_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_start,
  input  logic fire_stop,
  output logic start_o,
  output logic stop_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= fire_start;
      stop_o  <= fire_stop;
    end
  end

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
  import alias_regbank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              hw_alarm_set,
  input  logic              hw_drdy_set,
  input  logic              hw_above,
  output logic              alarm_ie,
  output logic [1:0]        alarm_mode,
  output logic              mon_enable,
  output logic [1:0]        meas_mode,
  output logic [1:0]        res_sel,
  output logic              start_strobe,
  output logic              stop_strobe,
  output logic [15:0]       thr_level,
  output logic [23:0]       period_cnt,
  output logic              refdiv_en,
  output logic [7:0]        refdiv_val,
  output logic              alarm_flag,
  output logic              drdy_flag
);

  logic [NREG-1:0] hit;
  alias_op_e       op;
  logic [DW-1:0]   q      [NREG];
  logic [DW-1:0]   hw_vec [NREG];

  arb_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit),
    .op   (op)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) hw_vec[i] = '0;
    hw_vec[IDX_STAT][ALARM_BIT] = hw_alarm_set;
    hw_vec[IDX_STAT][DRDY_BIT]  = hw_drdy_set;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    arb_reg #(.MASK(REG_MASK[g])) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_wr & hit[g]),
      .op     (op),
      .wdata  (bus_wdata),
      .hw_set (hw_vec[g]),
      .q      (q[g])
    );
  end

  logic cmd_write;
  assign cmd_write = bus_wr & hit[IDX_MCTL] & (op != OP_CLR);

  arb_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire_start (cmd_write & bus_wdata[START_BIT]),
    .fire_stop  (cmd_write & bus_wdata[STOP_BIT]),
    .start_o    (start_strobe),
    .stop_o     (stop_strobe)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) bus_rdata = q[i];
    end
    if (hit[IDX_STAT]) bus_rdata[ABOVE_BIT] = hw_above;
  end

  assign alarm_ie   = q[IDX_ACTL][9];
  assign alarm_mode = q[IDX_ACTL][3:2];
  assign alarm_flag = q[IDX_STAT][ALARM_BIT];
  assign drdy_flag  = q[IDX_STAT][DRDY_BIT];
  assign thr_level  = q[IDX_THR][31:16];
  assign mon_enable = q[IDX_MCTL][31];
  assign meas_mode  = q[IDX_MCTL][25:24];
  assign res_sel    = q[IDX_MCTL][19:18];
  assign period_cnt = q[IDX_PER][23:0];
  assign refdiv_en  = q[IDX_DIV][31];
  assign refdiv_val = q[IDX_DIV][23:16];

endmodule

// File: rtl/alias_regbank_sva.sv
module alias_regbank_sva #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              hw_alarm_set,
  input logic              start_strobe,
  input logic [15:0]       thr_level,
  input logic [23:0]       period_cnt,
  input logic              alarm_flag
);

  localparam logic [ADDR_W-1:0] THR_A  = ADDR_W'(12'h030);
  localparam logic [ADDR_W-1:0] MCTL_A = ADDR_W'(12'h200);

  logic thr_hit;
  logic mctl_hit;
  assign thr_hit  = bus_wr && (bus_addr[ADDR_W-1:4] == THR_A[ADDR_W-1:4]);
  assign mctl_hit = bus_wr && (bus_addr[ADDR_W-1:4] == MCTL_A[ADDR_W-1:4]);

  assert_base_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit && bus_addr[3:2] == 2'd0) |=> thr_level == $past(bus_wdata[31:16]));

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit && bus_addr[3:2] == 2'd1)
      |=> thr_level == ($past(thr_level) | $past(bus_wdata[31:16])));

  assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit && bus_addr[3:2] == 2'd2)
      |=> thr_level == ($past(thr_level) & ~$past(bus_wdata[31:16])));

  assert_tog_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hit && bus_addr[3:2] == 2'd3)
      |=> thr_level == ($past(thr_level) ^ $past(bus_wdata[31:16])));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(thr_level) && $stable(period_cnt)));

  assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_strobe |-> $past(mctl_hit && bus_addr[3:2] != 2'd2 && bus_wdata[30]));

  assert_hw_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_alarm_set |=> alarm_flag);

endmodule

bind alias_regbank alias_regbank_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/alias_regbank_tb_top.sv
module alias_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_alarm_set = 1'b0;
  logic        hw_drdy_set = 1'b0;
  logic        hw_above = 1'b0;
  logic        alarm_ie, mon_enable, start_strobe, stop_strobe;
  logic        refdiv_en, alarm_flag, drdy_flag;
  logic [1:0]  alarm_mode, meas_mode, res_sel;
  logic [15:0] thr_level;
  logic [23:0] period_cnt;
  logic [7:0]  refdiv_val;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic got_start, got_stop;
  logic [31:0] model [6];

  always #5 clk = ~clk;

  alias_regbank #(.ADDR_W(12)) dut_i (.*);

  function automatic logic [31:0] mask_of(int i);
    case (i)
      0: return 32'h0000_020C;
      1: return 32'h0001_0200;
      2: return 32'hFFFF_0000;
      3: return 32'h830C_0000;
      4: return 32'h00FF_FFFF;
      default: return 32'h80FF_0000;
    endcase
  endfunction

  function automatic logic [11:0] ofs_of(int i);
    case (i)
      0: return 12'h000;
      1: return 12'h010;
      2: return 12'h030;
      3: return 12'h200;
      4: return 12'h270;
      default: return 12'h280;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    got_start = start_strobe;
    got_stop = stop_strobe;
  endtask

  task automatic read_chk(string req, logic [11:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic fields_chk(string req);
    logic [63:0] act, exp;
    act = 64'({alarm_ie, alarm_mode, mon_enable, meas_mode, res_sel, thr_level,
               period_cnt, refdiv_en, refdiv_val, alarm_flag, drdy_flag});
    exp = 64'({model[0][9], model[0][3:2], model[3][31], model[3][25:24],
               model[3][19:18], model[2][31:16], model[4][23:0], model[5][31],
               model[5][23:16], model[1][9], model[1][16]});
    check(req, act, exp);
  endtask

  task automatic all_regs_chk(string req);
    for (int i = 0; i < 6; i++) read_chk(req, ofs_of(i), model[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
    pats[2] = 32'h0F0F_F0F0; pats[3] = 32'h1234_8765;
    for (int i = 0; i < 6; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    all_regs_chk("R10 reset read");
    fields_chk("R10 reset fields");
    check("R10 reset strobes", 64'({start_strobe, stop_strobe}), 64'(0));

    // R1-R7 sweep: every register, every alias op, several patterns
    for (int i = 0; i < 6; i++) begin
      for (int op = 0; op < 4; op++) begin
        for (int p = 0; p < 4; p++) begin
          logic [31:0] d, cur, nxt;
          d = pats[p] ^ (32'(op) << (4 * i));
          cur = model[i];
          case (op)
            0: nxt = d;
            1: nxt = cur | d;
            2: nxt = cur & ~d;
            default: nxt = cur ^ d;
          endcase
          model[i] = nxt & mask_of(i);
          do_write(ofs_of(i) | 12'(op << 2), d);
          check($sformatf("R7 start strobe reg%0d op%0d", i, op), 64'(got_start),
                64'((i == 3) && (op != 2) && d[30]));
          check($sformatf("R7 stop strobe reg%0d op%0d", i, op), 64'(got_stop),
                64'((i == 3) && (op != 2) && d[29]));
          case (op)
            0: read_chk("R1 base write", ofs_of(i), model[i]);
            1: read_chk("R2 set alias", ofs_of(i), model[i]);
            2: read_chk("R3 clear alias", ofs_of(i), model[i]);
            default: read_chk("R4 toggle alias", ofs_of(i), model[i]);
          endcase
          for (int k = 1; k < 4; k++) read_chk("R5 alias read", ofs_of(i) | 12'(k << 2), model[i]);
          fields_chk("R6 field outputs");
        end
      end
    end

    // R7: strobe lasts a single cycle
    do_write(12'h204, 32'h6000_0000);
    check("R7 strobes high", 64'({got_start, got_stop}), 64'(2'b11));
    @(negedge clk);
    check("R7 strobes drop", 64'({start_strobe, stop_strobe}), 64'(0));

    // R5: unmapped addresses
    do_write(12'h100, 32'hFFFF_FFFF);
    do_write(12'h3F4, 32'hFFFF_FFFF);
    read_chk("R5 unmapped read", 12'h100, 32'h0);
    read_chk("R5 unmapped read", 12'h3F4, 32'h0);
    all_regs_chk("R5 unmapped write no effect");

    // R8: hardware set beats a simultaneous software clear
    do_write(12'h014, 32'h0001_0200);
    model[1] = 32'h0001_0200;
    @(negedge clk);
    bus_addr = 12'h018; bus_wdata = 32'h0001_0200; bus_wr = 1'b1; hw_alarm_set = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; hw_alarm_set = 1'b0;
    model[1] = 32'h0000_0200;
    read_chk("R8 hw set wins", 12'h010, model[1]);
    fields_chk("R8 flags after clash");
    do_write(12'h018, 32'h0000_0200);
    model[1] = 32'h0;
    read_chk("R8 sw clear alone", 12'h010, model[1]);
    @(negedge clk);
    hw_drdy_set = 1'b1;
    @(negedge clk);
    hw_drdy_set = 1'b0;
    model[1] = 32'h0001_0000;
    read_chk("R8 hw drdy set", 12'h01C, model[1]);

    // R9: live comparator bit
    hw_above = 1'b1;
    read_chk("R9 above live", 12'h010, model[1] | 32'h2000);
    read_chk("R9 above at alias", 12'h018, model[1] | 32'h2000);
    do_write(12'h018, 32'h0000_2000);
    read_chk("R9 clear has no effect", 12'h010, model[1] | 32'h2000);
    hw_above = 1'b0;
    do_write(12'h014, 32'h0000_2000);
    read_chk("R9 set has no effect", 12'h010, model[1]);
    fields_chk("R6 final fields");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule